// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a 16 KB data cache with 16-byte lines organised as 512 sets of two ways. A CPU read compares the address tag against the tags of both ways of the selected set at once. An output multiplexer presents the data word and the tag of the matching way. A read hit returns its word in the request cycle with no stall. On a miss the CPU is held while the whole line is fetched from the next memory level and written into a victim way. The request is then repeated internally and hits.

Writes follow a write-through, write-allocate policy. A write that hits updates the cached word and sends the same word to memory. The CPU stays stalled until memory acknowledges the write. A write that misses first brings the line into the cache and then completes as a write hit. In each set, a fill goes to the first empty way, checking way 0 before way 1. Once both ways are occupied, a per-set toggle picks the victim, so the two ways take turns being replaced.

Top module: `dcache2w`

## Requirements
- R1: After reset every way of every set is invalid, so the first access to any address misses; with no request pending the CPU is not stalled and no memory request is raised.
- R2: A read miss raises cpuStall in the request cycle and issues exactly one line read (memWe low) at the line-aligned word address (word address with its two lowest bits cleared). The requested word is then returned: word k of a line is memLine bits [32k+31:32k], and k is word-address bits [1:0].
- R3: A read hit drops cpuStall in the request cycle, produces no memory traffic, and returns the cached word together with the stored tag (byte-address bits [31:13]) on cpuHitTag.
- R4: Two lines whose byte addresses differ by a multiple of 8 KB share a set, and both remain resident at the same time.
- R5: In a set with an empty way, a fill goes to way 0 if it is empty and otherwise to way 1. cpuHitWay reports 0 for way 0 and 1 for way 1.
- R6: In a set whose two ways are both valid, fills alternate between the ways, starting with way 0 after reset. Each set keeps its own alternation state, independent of fills in other sets.
- R7: A write hit stalls the CPU until memAck and sends one word write (memWe high) to memory with the CPU's word address and data. The same word is updated in the cache, so a later read of it hits and returns the new value.
- R8: A write miss performs one line fill and then one word write-through. Afterwards the written word and the rest of the fetched line hit.
- R9: dbgMultiHit, which flags both ways of a set matching one tag, stays low in operation. If such a match did occur, way 0 would be given priority.
- R10: Once raised, a memory request keeps memWordAddr, memWe and memWdata unchanged until the cycle of memAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access request, held until a cycle with cpuStall low |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWordAddr | input | 30 | CPU word address (byte address bits [31:2]) |
| cpuWdata | input | 32 | CPU write data |
| cpuRdata | output | 32 | Word read from the hitting way |
| cpuStall | output | 1 | CPU must hold its request |
| cpuHit | output | 1 | Address matches a valid way |
| cpuHitWay | output | 1 | Index of the matching way |
| cpuHitTag | output | 19 | Tag stored in the matching way |
| dbgMultiHit | output | 1 | Both ways match (illegal state) |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = word write-through, 0 = line read |
| memWordAddr | output | 30 | Memory word address |
| memWdata | output | 32 | Write-through data |
| memLine | input | 128 | Line returned by memory |
| memAck | input | 1 | One-cycle completion from memory |

## Verification
The main function is tested with three address patterns. The first is a cold miss followed by hits in the same line, which separates the fill path from the hit path and confirms word selection inside a line. The second puts lines 8 KB and 16 KB apart in one set; the reported way of each fill and the misses that follow show the empty-first order and the per-set alternation. The same pattern run in a second set separates a per-set toggle from a shared one. The third is a write hit and a write miss, each followed by read-back; this shows that the cache word is updated as well as memory, and that allocation comes before the write-through.

// File: rtl/dcache2w_pkg.sv
package dcache2w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WTHRU = 2'd2
  } dcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillLine;   // write memLine into victim way
    logic writeWord;  // write cpu word into hitting way
    logic lineAddr;   // memory address is line aligned
  } dcStrobes_t;

endpackage

// File: rtl/dcache2w_datapath.sv
module dcache2w_datapath
  import dcache2w_pkg::*;
#(
  parameter int INDEX_W  = 9,
  parameter int OFFSET_W = 4,
  parameter int WADDR_W  = 30,
  parameter int TAG_W    = WADDR_W - INDEX_W - (OFFSET_W - 2),
  parameter int LINE_W   = 8 << OFFSET_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WADDR_W-1:0] wordAddr,
  input  logic [31:0]        wdata,
  input  logic [LINE_W-1:0]  memLine,
  input  dcStrobes_t         strb,
  output logic               hit,
  output logic               hitWay,
  output logic [31:0]        rdata,
  output logic [TAG_W-1:0]   hitTag,
  output logic               multiHit,
  output logic [WADDR_W-1:0] memWordAddr
);
  localparam int NWAYS  = 2;
  localparam int SETS   = 1 << INDEX_W;
  localparam int WSEL_W = OFFSET_W - 2;
  localparam int WORD_W = 32;

  logic [INDEX_W-1:0] setIdx;
  logic [TAG_W-1:0]   tag;
  logic [WSEL_W-1:0]  wordSel;

  assign wordSel = wordAddr[WSEL_W-1:0];
  assign setIdx  = wordAddr[WSEL_W +: INDEX_W];
  assign tag     = wordAddr[WADDR_W-1 -: TAG_W];

  logic [SETS-1:0]   validQ [NWAYS];
  logic [SETS-1:0]   toggleQ;
  logic [TAG_W-1:0]  wayTag  [NWAYS];
  logic [LINE_W-1:0] wayLine [NWAYS];
  logic [NWAYS-1:0]  hitVec;
  logic [NWAYS-1:0]  hitSel;
  logic [NWAYS-1:0]  victimOh;
  logic              victimWay;
  logic              bothValid;

  assign bothValid = validQ[0][setIdx] && validQ[1][setIdx];

  // empty way first (way 0 before way 1), then the per-set toggle
  always_comb begin
    if (!validQ[0][setIdx])      victimWay = 1'b0;
    else if (!validQ[1][setIdx]) victimWay = 1'b1;
    else                         victimWay = toggleQ[setIdx];
  end
  assign victimOh = victimWay ? 2'b10 : 2'b01;

  genvar w;
  generate
    for (w = 0; w < NWAYS; w++) begin : g_way
      logic [TAG_W-1:0]  tagArr  [SETS];
      logic [LINE_W-1:0] dataArr [SETS];

      always_ff @(posedge clk) begin
        if (strb.fillLine && victimOh[w]) begin
          tagArr[setIdx]  <= tag;
          dataArr[setIdx] <= memLine;
        end else if (strb.writeWord && hitSel[w]) begin
          dataArr[setIdx][int'(wordSel)*WORD_W +: WORD_W] <= wdata;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN)                              validQ[w] <= '0;
        else if (strb.fillLine && victimOh[w])  validQ[w][setIdx] <= 1'b1;
      end

      assign wayTag[w]  = tagArr[setIdx];
      assign wayLine[w] = dataArr[setIdx];
      assign hitVec[w]  = validQ[w][setIdx] && (tagArr[setIdx] == tag);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                           toggleQ <= '0;
    else if (strb.fillLine && bothValid) toggleQ[setIdx] <= ~toggleQ[setIdx];
  end

  // way 0 wins if both match
  assign hitSel   = hitVec[0] ? 2'b01 : hitVec;
  assign hit      = |hitVec;
  assign multiHit = &hitVec;
  assign hitWay   = !hitVec[0];
  assign rdata    = wayLine[hitWay][int'(wordSel)*WORD_W +: WORD_W];
  assign hitTag   = wayTag[hitWay];

  assign memWordAddr = strb.lineAddr ?
                       {wordAddr[WADDR_W-1:WSEL_W], {WSEL_W{1'b0}}} : wordAddr;

endmodule

// File: rtl/dcache2w_control.sv
module dcache2w_control
  import dcache2w_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       hit,
  input  logic       memAck,
  output dcStrobes_t strb,
  output logic       cpuStall,
  output logic       memReq,
  output logic       memWe
);
  dcState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (cpuReq && !hit)      stateD = ST_FILL;
        else if (cpuReq && cpuWe) stateD = ST_WTHRU;
      end
      ST_FILL:  if (memAck) stateD = ST_IDLE;
      ST_WTHRU: if (memAck) stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    strb.fillLine  = (stateQ == ST_FILL) && memAck;
    strb.writeWord = (stateQ == ST_WTHRU) && memAck;
    strb.lineAddr  = (stateQ == ST_FILL);
    memReq         = (stateQ == ST_FILL) || (stateQ == ST_WTHRU);
    memWe          = (stateQ == ST_WTHRU);
    case (stateQ)
      ST_IDLE:  cpuStall = cpuReq && (!hit || cpuWe);
      ST_WTHRU: cpuStall = !memAck;
      default:  cpuStall = 1'b1;
    endcase
  end

endmodule

// File: rtl/dcache2w.sv
module dcache2w
  import dcache2w_pkg::*;
#(
  parameter int INDEX_W  = 9,
  parameter int OFFSET_W = 4,
  parameter int TAG_W    = 30 - INDEX_W - (OFFSET_W - 2),
  parameter int LINE_W   = 8 << OFFSET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [29:0]       cpuWordAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuStall,
  output logic              cpuHit,
  output logic              cpuHitWay,
  output logic [TAG_W-1:0]  cpuHitTag,
  output logic              dbgMultiHit,
  output logic              memReq,
  output logic              memWe,
  output logic [29:0]       memWordAddr,
  output logic [31:0]       memWdata,
  input  logic [LINE_W-1:0] memLine,
  input  logic              memAck
);
  dcStrobes_t strb;

  dcache2w_control ctrl_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .hit(cpuHit),
    .memAck(memAck), .strb(strb), .cpuStall(cpuStall), .memReq(memReq),
    .memWe(memWe)
  );

  dcache2w_datapath #(
    .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W), .WADDR_W(30),
    .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .wordAddr(cpuWordAddr), .wdata(cpuWdata),
    .memLine(memLine), .strb(strb), .hit(cpuHit), .hitWay(cpuHitWay),
    .rdata(cpuRdata), .hitTag(cpuHitTag), .multiHit(dbgMultiHit),
    .memWordAddr(memWordAddr)
  );

  assign memWdata = cpuWdata;

endmodule

// File: rtl/dcache2w_chk.sv
module dcache2w_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWe,
  input logic [29:0] cpuWordAddr,
  input logic        cpuHit,
  input logic        cpuStall,
  input logic        dbgMultiHit,
  input logic        memReq,
  input logic        memWe,
  input logic [29:0] memWordAddr,
  input logic [31:0] memWdata,
  input logic        memAck
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWordAddr) && $stable(memWe)
                          && $stable(memWdata));

  // R3
  read_hit_nostall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuWe && cpuHit |-> !cpuStall);

  // R2
  mem_while_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |-> cpuStall);

  // R8
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> !cpuReq || !$stable(cpuWordAddr) || cpuHit);

  // R9
  no_multi_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dbgMultiHit);
endmodule

bind dcache2w dcache2w_chk chk_i (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
  .cpuWordAddr(cpuWordAddr), .cpuHit(cpuHit), .cpuStall(cpuStall),
  .dbgMultiHit(dbgMultiHit), .memReq(memReq), .memWe(memWe),
  .memWordAddr(memWordAddr), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/dcache2w_tb_top.sv
module dcache2w_tb_top;
  localparam int LINE_W = 128;
  localparam int TAG_W  = 19;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN, cpuReq, cpuWe, cpuStall, cpuHit, cpuHitWay, dbgMultiHit;
  logic [29:0]       cpuWordAddr, memWordAddr;
  logic [31:0]       cpuWdata, cpuRdata, memWdata;
  logic [TAG_W-1:0]  cpuHitTag;
  logic              memReq, memWe, memAck;
  logic [LINE_W-1:0] memLine;

  dcache2w dut_i (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuWordAddr(cpuWordAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuStall(cpuStall), .cpuHit(cpuHit), .cpuHitWay(cpuHitWay),
    .cpuHitTag(cpuHitTag), .dbgMultiHit(dbgMultiHit), .memReq(memReq),
    .memWe(memWe), .memWordAddr(memWordAddr), .memWdata(memWdata),
    .memLine(memLine), .memAck(memAck)
  );

  int nRun = 0, nFail = 0;
  int fills = 0, writes = 0, holdErr = 0;
  logic [31:0] lastFill, lastWAddr, lastWData;
  bit multiSeen = 0;
  logic [31:0] wmem [logic [31:0]];

  function automatic logic [31:0] memWord(input logic [31:0] a);
    if (wmem.exists(a)) return wmem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  // memory model: acknowledges two negedges after accepting a request
  int cnt;
  logic busy;
  logic [29:0] acceptAddr;
  always @(negedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; busy <= 1'b0; cnt <= 0;
    end else if (memAck) begin
      memAck <= 1'b0; busy <= 1'b0;
    end else if (busy) begin
      if (memWordAddr != acceptAddr) holdErr++;
      if (cnt == 1) begin
        memAck <= 1'b1;
        if (memWe) begin
          wmem[{memWordAddr, 2'b00}] = memWdata;
          writes++;
          lastWAddr = {memWordAddr, 2'b00};
          lastWData = memWdata;
        end else begin
          fills++;
          lastFill = {memWordAddr, 2'b00};
          for (int i = 0; i < 4; i++)
            memLine[i*32 +: 32] <= memWord({memWordAddr, 2'b00} + 32'(i*4));
        end
      end
      cnt <= cnt - 1;
    end else if (memReq) begin
      busy <= 1'b1; cnt <= 2; acceptAddr <= memWordAddr;
    end
  end

  always @(negedge clk) if (rstN && dbgMultiHit) multiSeen = 1;

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic firstHit,
                        output logic way, output logic [TAG_W-1:0] tg);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuWordAddr = a[31:2]; cpuWdata = wd;
    #1 firstHit = !cpuStall;
    while (cpuStall) begin @(negedge clk); #1; end
    rd = cpuRdata; way = cpuHitWay; tg = cpuHitTag;
    @(posedge clk); #1;
    cpuReq = 1'b0; cpuWe = 1'b0;
  endtask

  task automatic doRead(input logic [31:0] a, input logic expHit,
                        input logic expWay, input string req);
    logic [31:0] rd; logic fh, way; logic [TAG_W-1:0] tg;
    int f0 = fills, w0 = writes;
    access(1'b0, a, 32'h0, rd, fh, way, tg);
    check(req, 32'(fh), 32'(expHit), "first-cycle hit");
    check(req, rd, memWord(a), "read data");
    check(req, 32'(way), 32'(expWay), "way");
    check(req, 32'(tg), 32'(a[31:13]), "tag");
    check(req, 32'(fills - f0 + writes - w0), expHit ? 32'd0 : 32'd1, "memory transfers");
    if (!expHit) check(req, lastFill, {a[31:4], 4'h0}, "fill address");
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [31:0] d,
                         input logic expFill, input logic expWay, input string req);
    logic [31:0] rd; logic fh, way; logic [TAG_W-1:0] tg;
    int f0 = fills, w0 = writes;
    access(1'b1, a, d, rd, fh, way, tg);
    check(req, 32'(fills - f0), expFill ? 32'd1 : 32'd0, "line fills");
    check(req, 32'(writes - w0), 32'd1, "word writes");
    check(req, lastWAddr, a, "write address");
    check(req, lastWData, d, "write data");
    check(req, 32'(way), 32'(expWay), "way");
    if (expFill) check(req, lastFill, {a[31:4], 4'h0}, "fill address");
  endtask

  task automatic t_reset;
    check("R1", 32'(cpuStall), 0, "idle stall");
    check("R1", 32'(memReq), 0, "idle memReq");
    check("R9", 32'(dbgMultiHit), 0, "multi-hit after reset");
  endtask

  task automatic t_coldMiss;  // R1 R2: empty cache, word 1 of the line
    doRead(32'h0000_0104, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_readHit;   // R3 and R5 (first fill landed in way 0)
    doRead(32'h0000_010C, 1'b1, 1'b0, "R3");
    doRead(32'h0000_0100, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_sameSet;   // R4 R5
    doRead(32'h0000_2104, 1'b0, 1'b1, "R5");
    doRead(32'h0000_0108, 1'b1, 1'b0, "R4");
    doRead(32'h0000_2100, 1'b1, 1'b1, "R4");
  endtask

  task automatic t_alternate; // R6
    doRead(32'h0000_4100, 1'b0, 1'b0, "R6");
    doRead(32'h0000_0104, 1'b0, 1'b1, "R6");
    doRead(32'h0000_4104, 1'b1, 1'b0, "R6");
    doRead(32'h0000_2100, 1'b0, 1'b0, "R6");
    // another set keeps its own toggle (still at way 0)
    doRead(32'h0000_0200, 1'b0, 1'b0, "R6");
    doRead(32'h0000_2200, 1'b0, 1'b1, "R6");
    doRead(32'h0000_4200, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_writeHit;  // R7
    doWrite(32'h0000_2108, 32'hDEAD_BEEF, 1'b0, 1'b0, "R7");
    doRead(32'h0000_2108, 1'b1, 1'b0, "R7");
  endtask

  task automatic t_writeMiss; // R8
    doWrite(32'h0000_6204, 32'h1234_5678, 1'b1, 1'b1, "R8");
    doRead(32'h0000_6204, 1'b1, 1'b1, "R8");
    doRead(32'h0000_620C, 1'b1, 1'b1, "R8");
    doRead(32'h0000_2200, 1'b0, 1'b0, "R6");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rstN = 1'b0; cpuReq = 1'b0; cpuWe = 1'b0; cpuWordAddr = '0; cpuWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_coldMiss();
    t_readHit();
    t_sameSet();
    t_alternate();
    t_writeHit();
    t_writeMiss();
    check("R9", 32'(multiSeen), 0, "multi-hit seen");
    check("R10", 32'(holdErr), 0, "request changed before ack");
    summary();
  end
endmodule